// File: doc/BRIEF.md
# Predicated Store Execution Unit

This block executes integer stores for a 64-bit register machine that tracks deferred-exception (NaT) bits beside its registers. A decoded store request arrives over a valid/ready handshake. It carries a qualifying predicate, the data and address register values with their NaT bits, an access size, a form (normal, sixteen-byte or spill), an optional signed 9-bit base-update immediate, an ordering type and a locality hint. Only one request is in flight at a time.

For each accepted request the unit decides whether a fault applies. If none does, it issues one memory write over a second valid/ready port, together with an invalidation to the advanced-load table. It then reports completion with a fault code. A base-update form also returns the updated base address and a prefetch hint for the cache line at that address. The sixteen-byte form merges the data register with the compare-and-store data value into one atomic 128-bit write. The spill form saves the data register's NaT bit into a 64-bit collection register that the unit holds.

Top module: `store_exec_unit`

## Requirements
- R1: A normal-form store writes the low 2^reqSizeLog bytes of reqData (reqSizeLog 0..3 gives 1, 2, 4 or 8 bytes) on byte lanes 0 upward of memData at memAddr = reqAddr. memByteEn has exactly those low lanes set, and all other lanes of memData are zero.
- R2: With reqAddrNat set, the request completes with doneFault = 2 (NaT consumption) and no memory write is issued.
- R3: With reqDataNat set, reqForm = 0 (normal) and reqForm = 1 (sixteen-byte) complete with doneFault = 2. reqForm = 2 (spill) does not fault on it.
- R4: A sixteen-byte store issues one write with memData = {csdValue, reqData}, so the data register sits at the address and csdValue at the address plus 8. All 16 bits of memByteEn are set.
- R5: A spill store writes 8 bytes. One cycle after its completion pulse, natColl bit reqAddr[8:3] equals reqDataNat and no other bit of natColl has changed.
- R6: With reqUpdate set, completion asserts wbValid with wbAddr = reqAddr + sign-extended reqImm. The memory write uses the original reqAddr and reqData.
- R7: reqUpdate together with the sixteen-byte form completes with doneFault = 1 (illegal operation) and no memory write.
- R8: Base-update completions assert pfValid with pfAddr = wbAddr with its low 6 bits cleared, and with pfHint = reqHint. memHint also carries reqHint.
- R9: Each memory write handshake asserts invValid in the same cycle, with invAddr = memAddr and invSize equal to the bytes written (1, 2, 4, 8 or 16).
- R10: A sixteen-byte store with pageWbOrNat low and wideEnable low completes with doneFault = 3 (unsupported reference) and no write. Either input high lets the write proceed.
- R11: memRelease equals reqRelease (1 for an ordered store with release semantics, 0 for a normal store).
- R12: When reqPred is 0 the request completes with doneFault = 0 and no memory write, invalidation, writeback, prefetch or natColl change, whatever the other fields hold.
- R13: reqReady is high only when the unit is idle. memValid, memAddr and memData hold steady while memReady is low.
- R14: Faults are ranked illegal (1) over NaT (2) over unsupported (3). Any fault suppresses the write, invalidation, writeback, prefetch and natColl update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Store request valid |
| reqReady | output | 1 | Unit idle, request accepted |
| reqPred | input | 1 | Qualifying predicate |
| reqForm | input | 2 | 0 normal, 1 sixteen-byte, 2 spill |
| reqSizeLog | input | 2 | Log2 of byte count in normal form |
| reqUpdate | input | 1 | Base-update form |
| reqImm | input | 9 | Signed base-update immediate |
| reqRelease | input | 1 | Ordered (release) store |
| reqHint | input | 2 | Locality hint |
| reqData | input | 64 | Data register value |
| reqDataNat | input | 1 | Data register NaT bit |
| reqAddr | input | 64 | Address register value |
| reqAddrNat | input | 1 | Address register NaT bit |
| csdValue | input | 64 | Compare-and-store data register |
| pageWbOrNat | input | 1 | Page is write-back cacheable or a NaT page |
| wideEnable | input | 1 | Sixteen-byte stores allowed on other pages |
| memValid | output | 1 | Memory write valid |
| memReady | input | 1 | Memory write accepted |
| memAddr | output | 64 | Write address |
| memData | output | 128 | Write data, lane 0 at the address |
| memByteEn | output | 16 | Byte lane enables |
| memRelease | output | 1 | Release semantics |
| memHint | output | 2 | Locality hint of the write |
| invValid | output | 1 | Advanced-load table invalidate |
| invAddr | output | 64 | Invalidate address |
| invSize | output | 5 | Invalidate size in bytes |
| doneValid | output | 1 | Completion pulse |
| doneFault | output | 2 | 0 none, 1 illegal, 2 NaT, 3 unsupported |
| wbValid | output | 1 | Base register writeback valid |
| wbAddr | output | 64 | Updated base value |
| pfValid | output | 1 | Prefetch hint valid |
| pfAddr | output | 64 | Line-aligned prefetch address |
| pfHint | output | 2 | Prefetch locality hint |
| natColl | output | 64 | NaT collection register |

## Verification
The bench builds the unit with its default parameters: 64-bit data and addresses, a 9-bit immediate, 2-bit hints and 64-byte lines. At these values the spill index covers all 64 collection bits, and the sixteen-byte write fills the whole 128-bit memory port. Negative and positive immediates reach both directions of the base update. The stimulus table combines predicates, forms, NaT bits and page inputs so that every pair in the fault ranking is exercised. A directed stalled handshake brings the hold rules of the memory port within reach.

// File: rtl/store_exec_pkg.sv
package store_exec_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ILLEGAL = 2'd1,
    FLT_NAT     = 2'd2,
    FLT_UNSUPP  = 2'd3
  } faultT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } stateT;

  typedef struct packed {
    logic capture;
    logic commit;
  } strobeT;
endpackage

// File: rtl/store_ctrl.sv
module store_ctrl
  import store_exec_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   memReady,
  input  logic   storeGo,
  output logic   reqReady,
  output logic   memValid,
  output logic   doneValid,
  output strobeT strobes
);
  stateT state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (reqValid) stateNext = ST_ISSUE;
      ST_ISSUE: if (!storeGo || memReady) stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady        = (state == ST_IDLE);
  assign memValid        = (state == ST_ISSUE) && storeGo;
  assign doneValid       = (state == ST_DONE);
  assign strobes.capture = (state == ST_IDLE) && reqValid;
  assign strobes.commit  = (state == ST_DONE) && storeGo;
endmodule

// File: rtl/store_dp.sv
module store_dp
  import store_exec_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 64,
  parameter int IMM_W    = 9,
  parameter int HINT_W   = 2,
  parameter int LINE_LOG = 6,
  localparam int LANES   = 2 * DATA_W / 8,
  localparam int CNT_W   = $clog2(LANES) + 1,
  localparam int IDX_W   = $clog2(DATA_W)
)(
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobes,
  input  logic                reqPred,
  input  logic [1:0]          reqForm,
  input  logic [1:0]          reqSizeLog,
  input  logic                reqUpdate,
  input  logic [IMM_W-1:0]    reqImm,
  input  logic                reqRelease,
  input  logic [HINT_W-1:0]   reqHint,
  input  logic [DATA_W-1:0]   reqData,
  input  logic                reqDataNat,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqAddrNat,
  input  logic [DATA_W-1:0]   csdValue,
  input  logic                pageWbOrNat,
  input  logic                wideEnable,
  output logic                storeGo,
  output faultT               faultCode,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [2*DATA_W-1:0] memData,
  output logic [LANES-1:0]    memByteEn,
  output logic                memRelease,
  output logic [HINT_W-1:0]   memHint,
  output logic [CNT_W-1:0]    byteCount,
  output logic                wbValid,
  output logic [ADDR_W-1:0]   wbAddr,
  output logic                pfValid,
  output logic [ADDR_W-1:0]   pfAddr,
  output logic [HINT_W-1:0]   pfHint,
  output logic [DATA_W-1:0]   natColl
);
  localparam logic [ADDR_W-1:0] LINE_MASK = {{(ADDR_W-LINE_LOG){1'b1}}, {LINE_LOG{1'b0}}};

  logic                predQ, updQ, relQ, dataNatQ, addrNatQ, pageOkQ, wideOkQ;
  logic [1:0]          formQ, sizeLogQ;
  logic [IMM_W-1:0]    immQ;
  logic [HINT_W-1:0]   hintQ;
  logic [DATA_W-1:0]   dataQ, csdQ;
  logic [ADDR_W-1:0]   addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predQ <= 1'b0; updQ <= 1'b0; relQ <= 1'b0;
      dataNatQ <= 1'b0; addrNatQ <= 1'b0; pageOkQ <= 1'b0; wideOkQ <= 1'b0;
      formQ <= '0; sizeLogQ <= '0; immQ <= '0; hintQ <= '0;
      dataQ <= '0; csdQ <= '0; addrQ <= '0;
    end else if (strobes.capture) begin
      predQ <= reqPred; updQ <= reqUpdate; relQ <= reqRelease;
      dataNatQ <= reqDataNat; addrNatQ <= reqAddrNat;
      pageOkQ <= pageWbOrNat; wideOkQ <= wideEnable;
      formQ <= reqForm; sizeLogQ <= reqSizeLog; immQ <= reqImm; hintQ <= reqHint;
      dataQ <= reqData; csdQ <= csdValue; addrQ <= reqAddr;
    end
  end

  logic isWide, isSpill;
  assign isWide  = (formQ == 2'd1);
  assign isSpill = (formQ == 2'd2);

  // fault ranking: illegal, then NaT consumption, then unsupported page
  always_comb begin
    if (!predQ)                                faultCode = FLT_NONE;
    else if (isWide && updQ)                   faultCode = FLT_ILLEGAL;
    else if (addrNatQ || (dataNatQ && !isSpill)) faultCode = FLT_NAT;
    else if (isWide && !pageOkQ && !wideOkQ)   faultCode = FLT_UNSUPP;
    else                                       faultCode = FLT_NONE;
  end
  assign storeGo = predQ && (faultCode == FLT_NONE);

  always_comb begin
    if (isWide)       byteCount = CNT_W'(2 * DATA_W / 8);
    else if (isSpill) byteCount = CNT_W'(DATA_W / 8);
    else              byteCount = CNT_W'(1) << sizeLogQ;
  end

  logic [DATA_W-1:0] lowData;
  for (genvar i = 0; i < LANES; i++) begin : g_lane_en
    assign memByteEn[i] = (CNT_W'(i) < byteCount);
  end
  for (genvar i = 0; i < DATA_W / 8; i++) begin : g_lane_data
    assign lowData[8*i +: 8] = (CNT_W'(i) < byteCount) ? dataQ[8*i +: 8] : 8'h00;
  end

  assign memData    = isWide ? {csdQ, dataQ} : {{DATA_W{1'b0}}, lowData};
  assign memAddr    = addrQ;
  assign memRelease = relQ;
  assign memHint    = hintQ;

  assign wbAddr  = addrQ + {{(ADDR_W-IMM_W){immQ[IMM_W-1]}}, immQ};
  assign wbValid = strobes.commit && updQ;
  assign pfValid = strobes.commit && updQ;
  assign pfAddr  = wbAddr & LINE_MASK;
  assign pfHint  = hintQ;

  always_ff @(posedge clk) begin
    if (!rstN) natColl <= '0;
    else if (strobes.commit && isSpill) natColl[addrQ[3 +: IDX_W]] <= dataNatQ;
  end
endmodule

// File: rtl/store_exec_unit.sv
module store_exec_unit
  import store_exec_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 64,
  parameter int IMM_W    = 9,
  parameter int HINT_W   = 2,
  parameter int LINE_LOG = 6,
  localparam int LANES   = 2 * DATA_W / 8,
  localparam int CNT_W   = $clog2(LANES) + 1
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqPred,
  input  logic [1:0]          reqForm,
  input  logic [1:0]          reqSizeLog,
  input  logic                reqUpdate,
  input  logic [IMM_W-1:0]    reqImm,
  input  logic                reqRelease,
  input  logic [HINT_W-1:0]   reqHint,
  input  logic [DATA_W-1:0]   reqData,
  input  logic                reqDataNat,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqAddrNat,
  input  logic [DATA_W-1:0]   csdValue,
  input  logic                pageWbOrNat,
  input  logic                wideEnable,
  output logic                memValid,
  input  logic                memReady,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [2*DATA_W-1:0] memData,
  output logic [LANES-1:0]    memByteEn,
  output logic                memRelease,
  output logic [HINT_W-1:0]   memHint,
  output logic                invValid,
  output logic [ADDR_W-1:0]   invAddr,
  output logic [CNT_W-1:0]    invSize,
  output logic                doneValid,
  output logic [1:0]          doneFault,
  output logic                wbValid,
  output logic [ADDR_W-1:0]   wbAddr,
  output logic                pfValid,
  output logic [ADDR_W-1:0]   pfAddr,
  output logic [HINT_W-1:0]   pfHint,
  output logic [DATA_W-1:0]   natColl
);
  strobeT strobes;
  logic   storeGo;
  faultT  faultCode;
  logic [CNT_W-1:0] byteCount;

  store_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReady(memReady),
    .storeGo(storeGo), .reqReady(reqReady), .memValid(memValid),
    .doneValid(doneValid), .strobes(strobes)
  );

  store_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_W(IMM_W),
    .HINT_W(HINT_W), .LINE_LOG(LINE_LOG)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqPred(reqPred), .reqForm(reqForm), .reqSizeLog(reqSizeLog),
    .reqUpdate(reqUpdate), .reqImm(reqImm), .reqRelease(reqRelease),
    .reqHint(reqHint), .reqData(reqData), .reqDataNat(reqDataNat),
    .reqAddr(reqAddr), .reqAddrNat(reqAddrNat), .csdValue(csdValue),
    .pageWbOrNat(pageWbOrNat), .wideEnable(wideEnable),
    .storeGo(storeGo), .faultCode(faultCode),
    .memAddr(memAddr), .memData(memData), .memByteEn(memByteEn),
    .memRelease(memRelease), .memHint(memHint), .byteCount(byteCount),
    .wbValid(wbValid), .wbAddr(wbAddr), .pfValid(pfValid),
    .pfAddr(pfAddr), .pfHint(pfHint), .natColl(natColl)
  );

  assign invValid  = memValid && memReady;
  assign invAddr   = memAddr;
  assign invSize   = byteCount;
  assign doneFault = doneValid ? faultCode : FLT_NONE;
endmodule

// File: rtl/store_exec_checker.sv
module store_exec_checker #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
)(
  input logic                clk,
  input logic                rstN,
  input logic                reqReady,
  input logic                memValid,
  input logic                memReady,
  input logic [ADDR_W-1:0]   memAddr,
  input logic [2*DATA_W-1:0] memData,
  input logic                invValid,
  input logic                doneValid,
  input logic [1:0]          doneFault,
  input logic                wbValid,
  input logic                pfValid,
  input logic [DATA_W-1:0]   natColl
);
  p_mem_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memData));

  p_ready_idle_r13: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memValid && !doneValid);

  p_fault_quiet_r14: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneFault != 2'd0 |-> !wbValid && !pfValid);

  p_inv_on_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> memValid && memReady);

  p_prefetch_wb_r8: assert property (@(posedge clk) disable iff (!rstN)
    pfValid |-> wbValid && doneValid);

  p_natcoll_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    natColl != $past(natColl) |-> $past(doneValid));
endmodule

bind store_exec_unit store_exec_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_store_exec_unit.sv
module test_store_exec_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic reqValid = 0, reqPred = 0, reqUpdate = 0, reqRelease = 0;
  logic reqDataNat = 0, reqAddrNat = 0, pageWbOrNat = 0, wideEnable = 0, memReady = 0;
  logic [1:0] reqForm = 0, reqSizeLog = 0, reqHint = 0;
  logic [8:0] reqImm = 0;
  logic [63:0] reqData = 0, reqAddr = 0, csdValue = 0;
  logic reqReady, memValid, memRelease, invValid, doneValid, wbValid, pfValid;
  logic [63:0] memAddr, invAddr, wbAddr, pfAddr, natColl;
  logic [127:0] memData;
  logic [15:0] memByteEn;
  logic [1:0] memHint, doneFault, pfHint;
  logic [4:0] invSize;

  store_exec_unit i_store_exec_unit (.*);

  int checks = 0, errors = 0;
  logic [63:0] shadowColl = '0;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pred, form, sizeLog, upd, imm, dNat, aNat, rel, pageOk, wide, expFault
  typedef struct packed {
    logic pred; logic [1:0] form; logic [1:0] sizeLog; logic upd; logic [8:0] imm;
    logic dNat; logic aNat; logic rel; logic pageOk; logic wide; logic [1:0] expFault;
  } vecT;
  localparam int NV = 16;
  localparam vecT VECS [NV] = '{
    '{1, 2'd0, 2'd0, 0, 9'h000, 0, 0, 0, 1, 0, 2'd0},
    '{1, 2'd0, 2'd1, 0, 9'h000, 0, 0, 1, 1, 0, 2'd0},
    '{1, 2'd0, 2'd2, 1, 9'h1F0, 0, 0, 0, 1, 0, 2'd0},
    '{1, 2'd0, 2'd3, 1, 9'h010, 0, 0, 1, 1, 0, 2'd0},
    '{1, 2'd1, 2'd3, 0, 9'h000, 0, 0, 0, 1, 0, 2'd0},
    '{1, 2'd1, 2'd3, 1, 9'h008, 0, 0, 0, 1, 0, 2'd1},
    '{1, 2'd0, 2'd3, 0, 9'h000, 0, 1, 0, 1, 0, 2'd2},
    '{1, 2'd0, 2'd3, 0, 9'h000, 1, 0, 0, 1, 0, 2'd2},
    '{1, 2'd2, 2'd0, 0, 9'h000, 1, 0, 0, 1, 0, 2'd0},
    '{1, 2'd1, 2'd3, 0, 9'h000, 0, 0, 0, 0, 0, 2'd3},
    '{1, 2'd1, 2'd3, 0, 9'h000, 0, 0, 1, 0, 1, 2'd0},
    '{1, 2'd1, 2'd3, 0, 9'h000, 1, 0, 0, 0, 0, 2'd2},
    '{0, 2'd0, 2'd3, 1, 9'h008, 1, 1, 0, 1, 0, 2'd0},
    '{1, 2'd1, 2'd3, 1, 9'h008, 0, 1, 0, 0, 0, 2'd1},
    '{1, 2'd2, 2'd0, 1, 9'h008, 1, 0, 0, 1, 0, 2'd0},
    '{1, 2'd0, 2'd3, 1, 9'h1F8, 1, 0, 0, 1, 0, 2'd2}
  };

  task automatic runVec(input vecT v, input int idx, input int stall);
    logic [63:0] d = 64'hF1E2D3C4B5A69788 + 64'(idx);
    logic [63:0] a = 64'h2000 + 64'(idx) * 64'h48;
    logic [63:0] csd = 64'h0BADC0DE00000000 | 64'(idx);
    int bytes = (v.form == 2'd1) ? 16 : (v.form == 2'd2) ? 8 : (1 << v.sizeLog);
    bit expMem = v.pred && (v.expFault == 2'd0);
    logic [63:0] expWb = a + {{55{v.imm[8]}}, v.imm};
    logic [127:0] expData;
    logic [15:0] expBe;
    int memSeen = 0, invSeen = 0, waited = 0;
    bit gotDone = 0, holdOk = 1;
    logic [1:0] gotFault = 0;
    logic gotWb = 0, gotPf = 0, gotRel = 0;
    logic [63:0] gotAddr = 0, gotInvAddr = 0, gotWbAddr = 0, gotPfAddr = 0, stallAddr = 0;
    logic [127:0] gotData = 0;
    logic [15:0] gotBe = 0;
    logic [4:0] gotInvSize = 0;
    logic [1:0] gotHint = 0, gotPfHint = 0;
    expBe = 16'((32'd1 << bytes) - 1);
    if (v.form == 2'd1) expData = {csd, d};
    else begin
      expData = '0;
      for (int b = 0; b < 8; b++) if (b < bytes) expData[8*b +: 8] = d[8*b +: 8];
    end
    @(negedge clk);
    reqValid = 1; reqPred = v.pred; reqForm = v.form; reqSizeLog = v.sizeLog;
    reqUpdate = v.upd; reqImm = v.imm; reqRelease = v.rel; reqHint = 2'(idx);
    reqData = d; reqDataNat = v.dNat; reqAddr = a; reqAddrNat = v.aNat;
    csdValue = csd; pageWbOrNat = v.pageOk; wideEnable = v.wide;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0; reqData = ~d; reqAddr = ~a; csdValue = ~csd;
    for (int c = 0; c < 40 && !gotDone; c++) begin
      if (memValid && waited >= stall) memReady = 1;
      else begin
        memReady = 0;
        if (memValid) begin
          if (waited == 0) stallAddr = memAddr;
          else if (memAddr != stallAddr) holdOk = 0;
          if (reqReady) holdOk = 0;
          waited++;
        end
      end
      #1;
      if (memValid && memReady) begin
        memSeen++; gotAddr = memAddr; gotData = memData; gotBe = memByteEn;
        gotRel = memRelease; gotHint = memHint;
      end
      if (invValid) begin invSeen++; gotInvAddr = invAddr; gotInvSize = invSize; end
      if (doneValid) begin
        gotDone = 1; gotFault = doneFault; gotWb = wbValid; gotPf = pfValid;
        gotWbAddr = wbAddr; gotPfAddr = pfAddr; gotPfHint = pfHint;
      end
      @(negedge clk);
    end
    memReady = 0;
    #1;
    check(gotDone, "R13 completion", 128'(gotDone), 128'd1);
    check(gotFault == v.expFault, "R14 fault code (R2 R3 R7 R10 R12)", 128'(gotFault), 128'(v.expFault));
    check(memSeen == int'(expMem), "R12 write count", 128'(memSeen), 128'(expMem));
    check(invSeen == int'(expMem), "R9 invalidate count", 128'(invSeen), 128'(expMem));
    if (stall > 0 && expMem) check(holdOk, "R13 stalled hold", 128'(holdOk), 128'd1);
    if (expMem) begin
      check(gotAddr == a, "R6 write uses old address", 128'(gotAddr), 128'(a));
      check(gotData == expData, "R1 R4 write data", gotData, expData);
      check(gotBe == expBe, "R1 R4 byte enables", 128'(gotBe), 128'(expBe));
      check(gotRel == v.rel, "R11 release", 128'(gotRel), 128'(v.rel));
      check(gotHint == 2'(idx), "R8 write hint", 128'(gotHint), 128'(idx % 4));
      check(gotInvAddr == a && gotInvSize == 5'(bytes), "R9 invalidate addr/size",
            {gotInvAddr, 59'd0, gotInvSize}, {a, 59'd0, 5'(bytes)});
    end
    check(gotWb == (expMem && v.upd), "R6 writeback valid", 128'(gotWb), 128'(expMem && v.upd));
    check(gotPf == (expMem && v.upd), "R8 prefetch valid", 128'(gotPf), 128'(expMem && v.upd));
    if (expMem && v.upd) begin
      check(gotWbAddr == expWb, "R6 updated base", 128'(gotWbAddr), 128'(expWb));
      check(gotPfAddr == (expWb & ~64'h3F), "R8 prefetch line", 128'(gotPfAddr), 128'(expWb & ~64'h3F));
      check(gotPfHint == 2'(idx), "R8 prefetch hint", 128'(gotPfHint), 128'(idx % 4));
    end
    if (expMem && v.form == 2'd2) shadowColl[a[8:3]] = v.dNat;
    check(natColl == shadowColl, "R5 collection register", 128'(natColl), 128'(shadowColl));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(reqReady == 1 && memValid == 0 && doneValid == 0, "R13 reset handshake",
          128'({reqReady, memValid, doneValid}), 128'(3'b100));
    check(natColl == 64'd0, "R5 reset collection", 128'(natColl), 128'd0);
    rstN = 1;
    for (int i = 0; i < NV; i++) runVec(VECS[i], i, 0);
    // stalled memory port with a normal store
    runVec('{1, 2'd0, 2'd2, 0, 9'h000, 0, 0, 1, 1, 0, 2'd0}, 20, 3);
    // clear a previously set spill bit at the same address as vector 8
    runVec('{1, 2'd2, 2'd0, 0, 9'h000, 0, 0, 0, 1, 0, 2'd0}, 8, 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R13 watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule